// File: doc/BRIEF.md
# Hierarchical L2 Request Arbiter

This block sits between a core's request sources and the shared second-level cache. Requests fall into three classes: stores, instruction-cache miss fills and data-cache miss fills. Each class has one requester per hardware thread. A thread may have a request pending in every class at once. The block chooses at most one request per cycle. First, a round-robin picker inside each class chooses a thread. Then a round-robin picker across the classes chooses which class's candidate goes out.

The L2 takes at most one request per cycle and may refuse on some cycles, for example while its internal queues are full. When a request is offered and refused, the block locks that choice. It keeps offering the same class, thread and payload until the L2 takes it. On the cycle of acceptance it sends a one-cycle grant to the winning requester, which then drops its request.

Top module: `l2_req_arb`

## Requirements
- R1: While reset is held and after it is released, both the class priority pointer and every per-class thread pointer start at 0. The first accepted request with all requesters active is therefore class 0, thread 0.
- R2: `l2Valid` is high in a cycle exactly when at least one request bit is set or a refused request is still held.
- R3: When nothing is held, the offered thread within the winning class is the first requesting thread found scanning upward from that class's thread pointer, wrapping around.
- R4: When nothing is held, the offered class is the first class with any pending request found scanning upward from the class pointer, wrapping around.
- R5: The pointers change only on an accept cycle (`l2Valid` and `l2Ready` both high). The winning class's thread pointer moves to the winner plus one, and the class pointer moves to the winning class plus one, each modulo its count.
- R6: After a cycle where `l2Valid` is high and `l2Ready` is low, the same class and thread are offered on every following cycle until one is accepted, whatever the request inputs do.
- R7: While a refused request is held, `l2Data` keeps the payload value it had on the first refused cycle, even if the requester's payload input changes.
- R8: `grant` has exactly one bit set, at the winner's index, on an accept cycle, and is all zeros on every other cycle.
- R9: Requester index is class*THREADS+thread, with class 0 = stores, 1 = instruction-cache fill, 2 = data-cache fill. That index selects the bit of `reqVec` and `grant` and the DATA_W-wide slice of `reqData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqVec | input | CLASSES*THREADS | Pending request per requester, index class*THREADS+thread |
| reqData | input | CLASSES*THREADS*DATA_W | Payload per requester, slice at the same index |
| l2Ready | input | 1 | L2 takes the offered request this cycle |
| l2Valid | output | 1 | A request is offered |
| l2Class | output | CLS_W | Class of the offered request |
| l2Thread | output | THR_W | Thread of the offered request |
| l2Data | output | DATA_W | Payload of the offered request |
| grant | output | CLASSES*THREADS | One-hot accept pulse to the winning requester |

## Verification
The offer, its payload and the grant are combinational, so each is due in the same cycle as the inputs that produce it. Pointer moves and the lock triggered by a refusal show up one edge later. The bench changes inputs one time unit after a rising edge and compares every output at the following falling edge. Only after that comparison does it advance its behavioural model to the state due after the next rising edge. This keeps same-cycle results and next-cycle state effects apart.

// File: rtl/l2_req_arb_pkg.sv
package l2_req_arb_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // first refused cycle: latch the live payload
    logic useHeld;  // a refused request is locked: drive the latched payload
  } arbStrobe_t;
endpackage

// File: rtl/l2_rr_pick.sv
module l2_rr_pick #(
  parameter int N = 4,
  parameter int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] ptr,
  output logic [W-1:0] idx,
  output logic         any
);
  int p;
  always_comb begin
    any = 1'b0;
    idx = '0;
    p   = 0;
    // scan downward so the lowest offset from ptr is assigned last
    for (int i = N - 1; i >= 0; i--) begin
      p = int'(ptr) + i;
      if (p >= N) p = p - N;
      if (req[p]) begin
        any = 1'b1;
        idx = W'(p);
      end
    end
  end
endmodule

// File: rtl/l2_req_arb_ctl.sv
module l2_req_arb_ctl
  import l2_req_arb_pkg::*;
#(
  parameter int CLASSES = 3,
  parameter int THREADS = 4,
  parameter int CLS_W   = $clog2(CLASSES),
  parameter int THR_W   = $clog2(THREADS),
  parameter int NREQ    = CLASSES * THREADS,
  parameter int IDX_W   = $clog2(NREQ)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NREQ-1:0]  reqVec,
  input  logic             l2Ready,
  output arbStrobe_t       strobe,
  output logic [IDX_W-1:0] selIdx,
  output logic             l2Valid,
  output logic [CLS_W-1:0] l2Class,
  output logic [THR_W-1:0] l2Thread,
  output logic [NREQ-1:0]  grant
);
  logic [THR_W-1:0] thrPtr [CLASSES];
  logic [THR_W-1:0] thrWin [CLASSES];
  logic [CLASSES-1:0] clsAny;
  logic [CLS_W-1:0] clsPtr, clsWin;
  logic anyReq, locked, accept;
  logic [CLS_W-1:0] heldClass;
  logic [THR_W-1:0] heldThread;

  for (genvar c = 0; c < CLASSES; c++) begin : g_thr
    l2_rr_pick #(.N(THREADS), .W(THR_W)) u_thrPick (
      .req(reqVec[c*THREADS +: THREADS]),
      .ptr(thrPtr[c]),
      .idx(thrWin[c]),
      .any(clsAny[c])
    );
  end

  l2_rr_pick #(.N(CLASSES), .W(CLS_W)) u_clsPick (
    .req(clsAny),
    .ptr(clsPtr),
    .idx(clsWin),
    .any(anyReq)
  );

  always_comb begin
    l2Class  = locked ? heldClass  : clsWin;
    l2Thread = locked ? heldThread : thrWin[clsWin];
    l2Valid  = locked | anyReq;
    accept   = l2Valid & l2Ready;
    selIdx   = IDX_W'(int'(l2Class) * THREADS + int'(l2Thread));
    grant    = '0;
    if (accept) grant[selIdx] = 1'b1;
    strobe.capture = l2Valid & ~l2Ready & ~locked;
    strobe.useHeld = locked;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < CLASSES; c++) thrPtr[c] <= '0;
      clsPtr     <= '0;
      locked     <= 1'b0;
      heldClass  <= '0;
      heldThread <= '0;
    end else if (accept) begin
      thrPtr[l2Class] <= (int'(l2Thread) == THREADS - 1) ? '0 : l2Thread + 1'b1;
      clsPtr          <= (int'(l2Class) == CLASSES - 1) ? '0 : l2Class + 1'b1;
      locked          <= 1'b0;
    end else if (l2Valid) begin
      locked     <= 1'b1;
      heldClass  <= l2Class;
      heldThread <= l2Thread;
    end
  end

  // R6
  hold_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (l2Valid && !l2Ready) |=> (l2Valid && l2Class == $past(l2Class) && l2Thread == $past(l2Thread)));
  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(grant));
  // R8
  grant_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|grant) |-> (l2Valid && l2Ready));
  // R5
  ptr_still_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(l2Valid && l2Ready) |=> $stable(clsPtr));
  // R3
  fresh_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (l2Valid && !locked) |-> reqVec[selIdx]);
endmodule

// File: rtl/l2_req_arb_dp.sv
module l2_req_arb_dp
  import l2_req_arb_pkg::*;
#(
  parameter int NREQ   = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(NREQ)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NREQ*DATA_W-1:0] reqData,
  input  arbStrobe_t             strobe,
  input  logic [IDX_W-1:0]       selIdx,
  output logic [DATA_W-1:0]      l2Data
);
  logic [DATA_W-1:0] liveData, heldData;

  assign liveData = reqData[int'(selIdx)*DATA_W +: DATA_W];
  assign l2Data   = strobe.useHeld ? heldData : liveData;

  always_ff @(posedge clk) begin
    if (!rstN)               heldData <= '0;
    else if (strobe.capture) heldData <= liveData;
  end

  // R7
  payload_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.capture) |-> (l2Data == $past(l2Data)));
endmodule

// File: rtl/l2_req_arb.sv
module l2_req_arb
  import l2_req_arb_pkg::*;
#(
  parameter int CLASSES = 3,
  parameter int THREADS = 4,
  parameter int DATA_W  = 32,
  parameter int CLS_W   = $clog2(CLASSES),
  parameter int THR_W   = $clog2(THREADS),
  parameter int NREQ    = CLASSES * THREADS
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NREQ-1:0]        reqVec,
  input  logic [NREQ*DATA_W-1:0] reqData,
  input  logic                   l2Ready,
  output logic                   l2Valid,
  output logic [CLS_W-1:0]       l2Class,
  output logic [THR_W-1:0]       l2Thread,
  output logic [DATA_W-1:0]      l2Data,
  output logic [NREQ-1:0]        grant
);
  localparam int IDX_W = $clog2(NREQ);
  arbStrobe_t strobe;
  logic [IDX_W-1:0] selIdx;

  l2_req_arb_ctl #(.CLASSES(CLASSES), .THREADS(THREADS)) u_ctl (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .l2Ready(l2Ready),
    .strobe(strobe), .selIdx(selIdx), .l2Valid(l2Valid),
    .l2Class(l2Class), .l2Thread(l2Thread), .grant(grant)
  );

  l2_req_arb_dp #(.NREQ(NREQ), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .reqData(reqData), .strobe(strobe),
    .selIdx(selIdx), .l2Data(l2Data)
  );
endmodule

// File: tb/l2_req_arb_tb.sv
module l2_req_arb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int C = 3, T = 4, N = 12, DW = 32;

  logic clk = 1'b0;
  logic rstN;
  logic [N-1:0] reqVec;
  logic [N*DW-1:0] reqData;
  logic l2Ready;
  logic l2Valid;
  logic [1:0] l2Class, l2Thread;
  logic [DW-1:0] l2Data;
  logic [N-1:0] grant;

  l2_req_arb u_dut (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .reqData(reqData), .l2Ready(l2Ready),
    .l2Valid(l2Valid), .l2Class(l2Class), .l2Thread(l2Thread), .l2Data(l2Data), .grant(grant)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int ptrT [C];
  int ptrC;
  bit lk;
  int lkC, lkT;
  logic [DW-1:0] lkD;
  int eC, eT, eIdx;
  bit eV;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected offer from the model state and current inputs
  task automatic predict();
    bit found;
    if (lk) begin
      eV = 1; eC = lkC; eT = lkT;
    end else begin
      eV = 0; eC = 0; eT = 0; found = 0;
      for (int k = 0; k < C; k++) begin
        int c;
        c = (ptrC + k) % C;
        if (!found && (reqVec[c*T +: T] != 0)) begin
          found = 1; eV = 1; eC = c;
        end
      end
      if (eV) begin
        found = 0;
        for (int k = 0; k < T; k++) begin
          int t;
          t = (ptrT[eC] + k) % T;
          if (!found && reqVec[eC*T + t]) begin found = 1; eT = t; end
        end
      end
    end
    eIdx = eC*T + eT;
  endtask

  task automatic compareAndAdvance();
    logic [DW-1:0] eD;
    logic [N-1:0] eG;
    predict();
    eD = lk ? lkD : reqData[eIdx*DW +: DW];
    eG = (eV && l2Ready) ? (N'(1) << eIdx) : '0;
    check("R2 valid", 64'(l2Valid), 64'(eV));
    check("R8 grant", 64'(grant), 64'(eG));
    if (eV) begin
      check("R4 R6 class", 64'(l2Class), 64'(eC));
      check("R3 R6 thread", 64'(l2Thread), 64'(eT));
      check("R7 R9 data", 64'(l2Data), 64'(eD));
    end
    // R5: model state for the next edge
    if (eV && l2Ready) begin
      ptrT[eC] = (eT + 1) % T;
      ptrC = (eC + 1) % C;
      lk = 0;
    end else if (eV && !lk) begin
      lk = 1; lkC = eC; lkT = eT; lkD = eD;
    end
  endtask

  // One cycle: drive at posedge+1, compare at negedge, granted requester drops
  task automatic cycle(int reqPct, int readyPct);
    @(posedge clk);
    #1;
    for (int i = 0; i < N; i++) begin
      if (!reqVec[i] && (($urandom % 100) < reqPct)) reqVec[i] = 1'b1;
      reqData[i*DW +: DW] = $urandom;
    end
    l2Ready = (($urandom % 100) < readyPct);
    @(negedge clk);
    compareAndAdvance();
    if (eV && l2Ready) begin
      @(posedge clk);
      #1 reqVec[eIdx] = 1'b0;
      @(negedge clk);
      compareAndAdvance();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqVec = '0; reqData = '0; l2Ready = 1'b0;
    for (int c = 0; c < C; c++) ptrT[c] = 0;
    ptrC = 0; lk = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset valid", 64'(l2Valid), 64'd0);
    check("R1 reset grant", 64'(grant), 64'd0);
    rstN = 1'b1;

    // R1: all requesters active, first winner is class 0 thread 0
    @(posedge clk); #1;
    reqVec = '1; l2Ready = 1'b1;
    for (int i = 0; i < N; i++) reqData[i*DW +: DW] = 32'hA000 + i;
    @(negedge clk);
    check("R1 first class", 64'(l2Class), 64'd0);
    check("R1 first thread", 64'(l2Thread), 64'd0);
    compareAndAdvance();
    @(posedge clk); #1 reqVec[eIdx] = 1'b0;
    @(negedge clk); compareAndAdvance();

    // R3 R4: saturated rotation, L2 always ready
    repeat (40) cycle(100, 100);
    // R9: single requester, class 1 thread 2 at index 6
    while (reqVec != 0) cycle(0, 100);
    @(posedge clk); #1;
    reqVec = '0; reqVec[6] = 1'b1; reqData[6*DW +: DW] = 32'h600D_0006; l2Ready = 1'b0;
    @(negedge clk);
    check("R9 class", 64'(l2Class), 64'd1);
    check("R9 thread", 64'(l2Thread), 64'd2);
    check("R9 data", 64'(l2Data), 64'h600D_0006);
    compareAndAdvance();
    // R6 R7: long refusal with churning payloads and new requests
    repeat (12) cycle(60, 0);
    repeat (600) cycle(50, 30);
    repeat (600) cycle(20, 100);
    repeat (600) cycle(70, 60);
    repeat (300) cycle(10, 20);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule